// File: doc/BRIEF.md
# Shared Video-Bus Memory Select Decoder

This block produces the chip selects for a small computer in which a CPU and a video controller take turns using one memory bus. A single phase input says who owns the bus. While the phase is low the CPU owns it. The CPU's in-block address lines are buffered onto the 14-bit video address bus, and the selects follow the block strobes the CPU side has already decoded. While the phase is high the video controller drives its own 14-bit address, the buffer is switched off, and every select comes from that address alone.

The video address space is a rotated view of the CPU map. Video 0x0000–0x1FFF is CPU block 4 (0x8000–0x9FFF), and video 0x2000–0x3FFF is CPU block 0 (0x0000–0x1FFF). In CPU mode the decoder builds the rotation itself: the block-4 strobe goes onto the top video address line. The character ROM answers only in the lowest 4 KB of video space. The colour RAM is held selected whenever the video side owns the bus. The 8 KB of block-0 RAM is split into eight 1 KB sub-selects. The decoder is purely combinational, so every output follows the inputs within the same cycle.

Top module: `vbus_memsel`

## Requirements
- R1: With phase_i high, vbus_addr_o equals vid_addr_i, buf_en_n_o is 1 (buffer off) and buf_dir_o is 1.
- R2: With phase_i low, vbus_addr_o equals {blk4_n_i, cpu_addr_i[12:0]}, buf_en_n_o is 0 and buf_dir_o equals cpu_rw_i.
- R3: chrrom_cs_n_o is 0 exactly when vbus_addr_o bits 13 and 12 are both 0, in either phase.
- R4: colram_cs_n_o is 0 throughout phase_i high; with phase_i low it equals colram_n_i.
- R5: With phase_i high, the block-0 RAM decode is enabled exactly when vbus_addr_o bit 13 is 1.
- R6: With phase_i low, the block-0 RAM decode is enabled exactly when blk4_n_i is 1 and blk0_n_i is 0.
- R7: When the decode is enabled, only ram_cs_n_o[k] is 0, where k is vbus_addr_o bits 12:10. When it is disabled, all eight bits are 1. At no time is more than one bit 0.
- R8: Video addresses wrap modulo 2^14. Address 0x3FFF selects RAM sub-select 7, and the address after it, 0x0000, selects the character ROM.
- R9: cpu_rw_i has no effect on any chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_i | input | 1 | Bus owner: 0 = CPU, 1 = video controller |
| cpu_addr_i | input | 13 | CPU address lines within a 8 KB block |
| cpu_rw_i | input | 1 | CPU read (1) / write (0) |
| blk0_n_i | input | 1 | CPU block-0 strobe, active low |
| blk4_n_i | input | 1 | CPU block-4 strobe, active low |
| colram_n_i | input | 1 | CPU colour-RAM area decode, active low |
| vid_addr_i | input | 14 | Address driven by the video controller |
| vbus_addr_o | output | 14 | Address on the shared video bus |
| buf_en_n_o | output | 1 | Address/data buffer enable, active low |
| buf_dir_o | output | 1 | Buffer direction, follows the CPU read line |
| chrrom_cs_n_o | output | 1 | Character ROM select, active low |
| colram_cs_n_o | output | 1 | Colour RAM select, active low |
| ram_cs_n_o | output | 8 | Block-0 RAM 1 KB sub-selects, active low |

## Verification
No register lies between any input and any output, so every result is due in the same cycle that its stimulus is applied. The bench changes the inputs just after a rising clock edge and compares the outputs at the following falling edge. By then the combinational paths have settled, and the next change of inputs has not yet happened. The bench sweeps every video address, and it pairs a spread of CPU addresses with every combination of the strobes.

// File: rtl/vbus_dec_pkg.sv
package vbus_dec_pkg;
  localparam int unsigned VBUS_AW = 14;
  localparam int unsigned SUBSEL_W = 3;

  typedef enum logic {
    OWNER_CPU   = 1'b0,
    OWNER_VIDEO = 1'b1
  } bus_owner_e;
endpackage

// File: rtl/vbus_addr_mux.sv
module vbus_addr_mux #(
  parameter int unsigned AW = 14
) (
  input  logic          phase_i,
  input  logic [AW-2:0] cpu_lo_i,
  input  logic          blk4_n_i,
  input  logic [AW-1:0] vid_addr_i,
  output logic [AW-1:0] vaddr_o,
  output logic          buf_en_n_o
);
  import vbus_dec_pkg::*;

  bus_owner_e owner;

  always_comb begin
    owner = bus_owner_e'(phase_i);
    if (owner == OWNER_VIDEO) begin
      vaddr_o    = vid_addr_i;
      buf_en_n_o = 1'b1;
    end else begin
      // rotation: block-4 strobe low places the CPU in the bottom half
      vaddr_o    = {blk4_n_i, cpu_lo_i};
      buf_en_n_o = 1'b0;
    end
  end
endmodule

// File: rtl/vbus_chrrom_sel.sv
module vbus_chrrom_sel (
  input  logic [1:0] top_bits_i,
  output logic       cs_n_o
);
  logic en_a_n;
  logic en_b_n;

  // two active-low enables that must both be low
  assign en_a_n = top_bits_i[1];
  assign en_b_n = top_bits_i[0];
  assign cs_n_o = en_a_n | en_b_n;
endmodule

// File: rtl/vbus_blk0_dec.sv
module vbus_blk0_dec #(
  parameter int unsigned SW = 3
) (
  input  logic               en_hi_i,
  input  logic               en_lo_n_i,
  input  logic [SW-1:0]      sel_i,
  output logic [(1<<SW)-1:0] cs_n_o
);
  localparam int unsigned NOUT = 1 << SW;

  logic active;
  assign active = en_hi_i & ~en_lo_n_i;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign cs_n_o[g] = ~(active && (sel_i == SW'(g)));
  end

  always_comb begin
    AST_SUBSEL_ONEHOT: assert ($onehot0(~cs_n_o)); // R7
    if (!en_hi_i || en_lo_n_i)
      AST_IDLE_WHEN_OFF: assert (&cs_n_o); // R7
  end
endmodule

// File: rtl/vbus_memsel.sv
module vbus_memsel
  import vbus_dec_pkg::*;
#(
  parameter int unsigned VA_W  = VBUS_AW,
  parameter int unsigned SUB_W = SUBSEL_W
) (
  input  logic                  phase_i,
  input  logic [VA_W-2:0]       cpu_addr_i,
  input  logic                  cpu_rw_i,
  input  logic                  blk0_n_i,
  input  logic                  blk4_n_i,
  input  logic                  colram_n_i,
  input  logic [VA_W-1:0]       vid_addr_i,
  output logic [VA_W-1:0]       vbus_addr_o,
  output logic                  buf_en_n_o,
  output logic                  buf_dir_o,
  output logic                  chrrom_cs_n_o,
  output logic                  colram_cs_n_o,
  output logic [(1<<SUB_W)-1:0] ram_cs_n_o
);
  localparam int unsigned NSUB = 1 << SUB_W;

  logic [VA_W-1:0] vaddr;
  logic            dec_en_hi;
  logic            dec_en_lo_n;

  vbus_addr_mux #(.AW(VA_W)) u_mux (
    .phase_i    (phase_i),
    .cpu_lo_i   (cpu_addr_i),
    .blk4_n_i   (blk4_n_i),
    .vid_addr_i (vid_addr_i),
    .vaddr_o    (vaddr),
    .buf_en_n_o (buf_en_n_o)
  );

  vbus_chrrom_sel u_rom (
    .top_bits_i (vaddr[VA_W-1 -: 2]),
    .cs_n_o     (chrrom_cs_n_o)
  );

  // buffer off: pull-down holds the low enable, address bit takes the high one
  always_comb begin
    if (phase_i) begin
      dec_en_hi     = vaddr[VA_W-1];
      dec_en_lo_n   = 1'b0;
      colram_cs_n_o = 1'b0;
      buf_dir_o     = 1'b1;
    end else begin
      dec_en_hi     = blk4_n_i;
      dec_en_lo_n   = blk0_n_i;
      colram_cs_n_o = colram_n_i;
      buf_dir_o     = cpu_rw_i;
    end
  end

  vbus_blk0_dec #(.SW(SUB_W)) u_ram (
    .en_hi_i   (dec_en_hi),
    .en_lo_n_i (dec_en_lo_n),
    .sel_i     (vaddr[VA_W-2 -: SUB_W]),
    .cs_n_o    (ram_cs_n_o)
  );

  assign vbus_addr_o = vaddr;

  always_comb begin
    AST_ROM_RAM_EXCL: assert (chrrom_cs_n_o || (ram_cs_n_o == {NSUB{1'b1}})); // R3
    if (phase_i)
      AST_BUF_OFF_VIDEO: assert (buf_en_n_o); // R1
    if (!phase_i)
      AST_CPU_FORWARD: assert (vbus_addr_o[VA_W-2:0] == cpu_addr_i); // R2
  end
endmodule

// File: tb/vbus_memsel_tb.sv
module vbus_memsel_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        phase, rw, b0n, b4n, coln;
  logic [12:0] caddr;
  logic [13:0] vaddr_in;
  logic [13:0] vbus;
  logic        ben_n, bdir, rom_n, col_n;
  logic [7:0]  ram_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vbus_memsel dut_i (
    .phase_i(phase), .cpu_addr_i(caddr), .cpu_rw_i(rw),
    .blk0_n_i(b0n), .blk4_n_i(b4n), .colram_n_i(coln),
    .vid_addr_i(vaddr_in), .vbus_addr_o(vbus), .buf_en_n_o(ben_n),
    .buf_dir_o(bdir), .chrrom_cs_n_o(rom_n), .colram_cs_n_o(col_n),
    .ram_cs_n_o(ram_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic p, logic [12:0] ca, logic r, logic n0, logic n4,
                       logic nc, logic [13:0] va);
    @(posedge clk);
    #1;
    phase = p; caddr = ca; rw = r; b0n = n0; b4n = n4; coln = nc; vaddr_in = va;
    @(negedge clk);
  endtask

  // full reference check of the current inputs
  task automatic check_all(string req);
    logic [13:0] ea;
    logic        en;
    logic [7:0]  er;
    ea = phase ? vaddr_in : {b4n, caddr};
    en = phase ? ea[13] : (b4n && !b0n);
    er = en ? ~(8'd1 << ea[12:10]) : 8'hFF;
    chk(phase ? "R1" : "R2", "vbus_addr", vbus, ea);
    chk(phase ? "R1" : "R2", "buf_en_n", ben_n, phase);
    chk(phase ? "R1" : "R2", "buf_dir", bdir, phase ? 1 : rw);
    chk("R3", "chrrom_cs_n", rom_n, ea[13] | ea[12]);
    chk("R4", "colram_cs_n", col_n, phase ? 0 : coln);
    chk(phase ? "R5" : "R6", "ram_cs_n", ram_n, er);
    chk("R7", "ram onehot0", $onehot0(~ram_n), 1);
  endtask

  task automatic t_idle;
    apply(1'b0, 13'h0, 1'b1, 1'b1, 1'b1, 1'b1, 14'h0);
    chk("R6", "idle ram_cs_n", ram_n, 8'hFF);
    chk("R4", "idle colram", col_n, 1);
    check_all("R2");
  endtask

  task automatic t_video_sweep;
    for (int a = 0; a < 16384; a++) begin
      apply(1'b1, 13'h1555, a[0], a[1], a[2], a[3], 14'(a));
      check_all("R5");
    end
  endtask

  task automatic t_cpu_sweep;
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8192; a += 8) begin
        apply(1'b0, 13'(a + (s & 7)), s[0], s[0], s[1], s[2], 14'h3FFF);
        check_all("R6");
      end
    end
  endtask

  task automatic t_disabled;
    // both strobes asserted low: block 4 -> decoder off
    apply(1'b0, 13'h0C00, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0);
    chk("R7", "disabled all high", ram_n, 8'hFF);
    chk("R3", "rom in block4 low", rom_n, 0);
    apply(1'b1, 13'h0, 1'b1, 1'b1, 1'b1, 1'b1, 14'h1C00);
    chk("R7", "video low half all high", ram_n, 8'hFF);
  endtask

  task automatic t_wrap;
    logic [13:0] nxt;
    apply(1'b1, 13'h0, 1'b1, 1'b1, 1'b1, 1'b1, 14'h3FFF);
    chk("R8", "top ram sub7", ram_n, 8'h7F);
    chk("R8", "top rom off", rom_n, 1);
    nxt = 14'h3FFF + 14'd1;
    apply(1'b1, 13'h0, 1'b1, 1'b1, 1'b1, 1'b1, nxt);
    chk("R8", "wrapped rom on", rom_n, 0);
    chk("R8", "wrapped ram off", ram_n, 8'hFF);
  endtask

  task automatic t_rw_ignored;
    logic       r0, c0;
    logic [7:0] m0;
    apply(1'b0, 13'h0800, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
    r0 = rom_n; c0 = col_n; m0 = ram_n;
    apply(1'b0, 13'h0800, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0);
    chk("R9", "rom vs rw", rom_n, r0);
    chk("R9", "colram vs rw", col_n, c0);
    chk("R9", "ram vs rw", ram_n, m0);
    chk("R9", "ram sub2 selected", ram_n, 8'hFB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = 1'b0; caddr = '0; rw = 1'b1; b0n = 1'b1; b4n = 1'b1; coln = 1'b1;
    vaddr_in = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_disabled();
    t_wrap();
    t_rw_ignored();
    t_video_sweep();
    t_cpu_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule